// File: doc/BRIEF.md
# Tick Timer and Interrupt Aggregator

This block turns the system clock into a slow periodic tick (10 ms at the default divide value) and gathers four interrupt sources into one active-low level interrupt line. The sources are the tick itself, the expiry of a reloadable countdown driven by the tick, and two event strobes from a neighbouring serial unit: transmitter empty and receiver full. Each source latches into a pending register. A mask register selects which pending bits may pull the interrupt line low.

Two further 8-bit timers run on the tick for software timeouts. The first is an escape timer. Its upper bit is a tag that the timer never changes, and only its lower seven bits count down. The second is a refresh timer that counts down to zero and then stays there. All registers sit behind a small synchronous write port and a combinational read port.

Top module: `tick_irq_hub`

## Requirements
- R1: A tick occurs once every TICK_DIV clock cycles. The first tick after reset release falls on the TICK_DIV-th rising edge.
- R2: Every tick sets pending bit 0.
- R3: On a tick, a countdown value of 1 loads the reload value (address 2) into the countdown (address 3) and sets pending bit 1. Any other value decrements by one, modulo 256, so 0 becomes 255. A write to address 3 loads the countdown directly.
- R4: A transmit-empty strobe sets pending bit 7 and a receive-full strobe sets pending bit 6. Either bit is set whatever its mask bit holds.
- R5: Writing the pending register (address 0) clears every bit written as 1 and leaves bits written as 0 unchanged. An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R6: irq_n goes low on the clock edge after pending AND mask (mask at address 1) becomes non-zero. It returns high on the edge after that AND becomes zero.
- R7: After reset, the mask reads 0x01, and the pending register, reload value, countdown and both timers read 0x00. irq_n is high.
- R8: On a tick, the escape timer (address 4) decrements when its low seven bits are non-zero. Bit 7 keeps its value. A timer whose low seven bits are zero does not change.
- R9: On a tick, the refresh timer (address 5) decrements when it is non-zero and stays at zero otherwise.
- R10: A register write takes priority over a tick update of the same register. Reads from addresses 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address for read and write |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| tx_empty_stb | input | 1 | One-cycle transmit-empty event |
| rx_full_stb | input | 1 | One-cycle receive-full event |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The hardest case to reach from the ports is an event that lands in the same cycle as a software clear of its own pending bit. The tick's phase is not visible outside the block, so the bench cannot place a clear on a tick edge on purpose. It therefore produces the collision with the receive-full strobe instead. The strobe and a write of 0x40 to the pending register are driven on the same clock edge, and the bench then checks that bit 6 is still set. Tick-driven timer checks are aligned to an observed tick: the bench polls pending bit 0, clears it, and then makes its writes inside the quiet window before the next tick.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int DW = 8;

  // register addresses
  localparam logic [2:0] A_PEND = 3'd0;
  localparam logic [2:0] A_MASK = 3'd1;
  localparam logic [2:0] A_CTOP = 3'd2;
  localparam logic [2:0] A_CCNT = 3'd3;
  localparam logic [2:0] A_ESC  = 3'd4;
  localparam logic [2:0] A_RFR  = 3'd5;

  // pending bit positions
  localparam int B_TICK = 0;
  localparam int B_CDN  = 1;
  localparam int B_RXF  = 6;
  localparam int B_TXE  = 7;

  localparam logic [DW-1:0] MASK_RST = 8'h01;

  // countdown step: {expired, next value}
  function automatic logic [DW:0] cdn_step(input logic [DW-1:0] cnt,
                                           input logic [DW-1:0] top);
    if (cnt == 8'd1) return {1'b1, top};
    return {1'b0, cnt - 8'd1};
  endfunction

  // escape timer step: only the low seven bits count
  function automatic logic [DW-1:0] esc_step(input logic [DW-1:0] v);
    if (v[DW-2:0] != '0) return v - 8'd1;
    return v;
  endfunction

  // refresh timer step: saturate at zero
  function automatic logic [DW-1:0] rfr_step(input logic [DW-1:0] v);
    if (v != '0) return v - 8'd1;
    return v;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned DIV = 160000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap_chk
      // R1: ticks are isolated single-cycle pulses
      a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tick_timers.sv
module tick_timers
  import tick_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_top,
  input  logic          wr_cnt,
  input  logic          wr_esc,
  input  logic          wr_rfr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] top_q,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] esc_q,
  output logic [DW-1:0] rfr_q,
  output logic          cdn_expire
);
  logic [DW:0] cdn_nx;

  assign cdn_nx     = cdn_step(cnt_q, top_q);
  assign cdn_expire = tick && !wr_cnt && cdn_nx[DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      cnt_q <= '0;
      esc_q <= '0;
      rfr_q <= '0;
    end else begin
      if (wr_top) top_q <= wdata;

      if (wr_cnt)    cnt_q <= wdata;
      else if (tick) cnt_q <= cdn_nx[DW-1:0];

      if (wr_esc)    esc_q <= wdata;
      else if (tick) esc_q <= esc_step(esc_q);

      if (wr_rfr)    rfr_q <= wdata;
      else if (tick) rfr_q <= rfr_step(rfr_q);
    end
  end

  // R3: expiry reloads the value held in the reload register
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    cdn_expire |=> (cnt_q == $past(top_q)));

  // R8: the tag bit of the escape timer never moves on a tick
  a_r8_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_esc) |=> (esc_q[DW-1] == $past(esc_q[DW-1])));

  // R9: refresh timer at zero stays at zero without a write
  a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rfr_q == '0 && !wr_rfr) |=> (rfr_q == '0));
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import tick_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  input  logic          wr_mask,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pend_q,
  output logic [DW-1:0] mask_q,
  output logic          irq_n
);
  logic [DW-1:0] live;

  assign live = pend_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
      irq_n  <= 1'b1;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | set_vec;
      if (wr_mask) mask_q <= wdata;
      irq_n  <= ~(|live);
    end
  end

  // R5: an event in the same cycle as a clear still lands
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R5: cleared bits without a coincident event are zero afterwards
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

  // R6: line level follows the masked pending state one edge later
  a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_n == !(|$past(pend_q & mask_q))));
endmodule

// File: rtl/tick_irq_hub.sv
module tick_irq_hub
  import tick_irq_pkg::*;
#(
  parameter int unsigned TICK_DIV = 160000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tx_empty_stb,
  input  logic       rx_full_stb,
  output logic       irq_n
);
  logic          tick;
  logic          cdn_expire;
  logic [DW-1:0] pend, mask, top, cnt, esc, rfr;
  logic [DW-1:0] set_vec, clr_vec;
  logic          wr_pend, wr_mask, wr_top, wr_cnt, wr_esc, wr_rfr;

  assign wr_pend = reg_wr && (reg_addr == A_PEND);
  assign wr_mask = reg_wr && (reg_addr == A_MASK);
  assign wr_top  = reg_wr && (reg_addr == A_CTOP);
  assign wr_cnt  = reg_wr && (reg_addr == A_CCNT);
  assign wr_esc  = reg_wr && (reg_addr == A_ESC);
  assign wr_rfr  = reg_wr && (reg_addr == A_RFR);

  tick_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  tick_timers u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_top     (wr_top),
    .wr_cnt     (wr_cnt),
    .wr_esc     (wr_esc),
    .wr_rfr     (wr_rfr),
    .wdata      (reg_wdata),
    .top_q      (top),
    .cnt_q      (cnt),
    .esc_q      (esc),
    .rfr_q      (rfr),
    .cdn_expire (cdn_expire)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_TICK] = tick;
    set_vec[B_CDN]  = cdn_expire;
    set_vec[B_RXF]  = rx_full_stb;
    set_vec[B_TXE]  = tx_empty_stb;
  end

  assign clr_vec = wr_pend ? reg_wdata : '0;

  irq_flags u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .wr_mask (wr_mask),
    .wdata   (reg_wdata),
    .pend_q  (pend),
    .mask_q  (mask),
    .irq_n   (irq_n)
  );

  always_comb begin
    case (reg_addr)
      A_PEND:  reg_rdata = pend;
      A_MASK:  reg_rdata = mask;
      A_CTOP:  reg_rdata = top;
      A_CCNT:  reg_rdata = cnt;
      A_ESC:   reg_rdata = esc;
      A_RFR:   reg_rdata = rfr;
      default: reg_rdata = '0;
    endcase
  end

  // R2: a tick is always recorded in pending bit 0
  a_r2_tick_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pend[B_TICK]);

  // R4: serial strobes land in their own pending bits
  a_r4_tx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_stb |=> pend[B_TXE]);
  a_r4_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_stb |=> pend[B_RXF]);
endmodule

// File: tb/tick_irq_hub_tb_top.sv
`timescale 1ns/1ps
module tick_irq_hub_tb_top;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       tx_empty_stb = 1'b0;
  logic       rx_full_stb = 1'b0;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_irq_hub #(.TICK_DIV(DIV)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .tx_empty_stb (tx_empty_stb),
    .rx_full_stb  (rx_full_stb),
    .irq_n        (irq_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // wait for an observed tick, clear its flag, return the detection cycle
  task automatic wait_tick(output int at);
    logic [7:0] d;
    d = 8'd0;
    while (!d[0]) begin
      @(negedge clk);
      rd(3'd0, d);
    end
    at = cyc;
    wr(3'd0, 8'h01);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd1, d); chk("R7 mask reset", d, 8'h01);
    rd(3'd0, d); chk("R7 pending reset", d, 8'h00);
    rd(3'd3, d); chk("R7 countdown reset", d, 8'h00);
    rd(3'd4, d); chk("R7 escape reset", d, 8'h00);
    chk("R7 irq_n reset", irq_n, 1);
  endtask

  task automatic t_first_tick;
    logic [7:0] d;
    int n;
    n = 0; d = 8'd0;
    @(negedge clk); rst_n = 1'b1;
    while (!d[0] && n < 100) begin
      @(negedge clk); n++;
      rd(3'd0, d);
    end
    chk("R1 first tick edge", n, DIV);
    chk("R2 tick sets bit0", d[0], 1);
    chk("R6 irq_n lags pending", irq_n, 1);
    @(negedge clk);
    chk("R6 irq_n low with tick enabled", irq_n, 0);
    wr(3'd0, 8'h01);
    rd(3'd0, d); chk("R5 tick bit cleared", d[0], 0);
    chk("R6 irq_n still low one edge", irq_n, 0);
    @(negedge clk);
    chk("R6 irq_n released", irq_n, 1);
  endtask

  task automatic t_period;
    int a, b;
    wait_tick(a);
    wait_tick(b);
    chk("R1 tick period", b - a, DIV);
  endtask

  task automatic t_countdown;
    logic [7:0] d;
    int t;
    wait_tick(t);
    wr(3'd2, 8'h03);
    wr(3'd3, 8'h02);
    wait_tick(t);
    rd(3'd3, d); chk("R3 countdown decrement", d, 8'h01);
    rd(3'd0, d); chk("R3 no expiry yet", d[1], 0);
    wait_tick(t);
    rd(3'd3, d); chk("R3 reload value", d, 8'h03);
    rd(3'd0, d); chk("R3 expiry flag", d[1], 1);
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h00);
    wait_tick(t);
    rd(3'd3, d); chk("R3 wrap from zero", d, 8'hFF);
    rd(3'd0, d); chk("R3 no expiry on wrap", d[1], 0);
  endtask

  task automatic t_timers;
    logic [7:0] d;
    int t;
    wait_tick(t);
    wr(3'd4, 8'h82);
    wr(3'd5, 8'h02);
    wait_tick(t);
    rd(3'd4, d); chk("R8 escape decrement tag set", d, 8'h81);
    rd(3'd5, d); chk("R9 refresh decrement", d, 8'h01);
    wait_tick(t);
    rd(3'd4, d); chk("R8 escape reaches tag only", d, 8'h80);
    rd(3'd5, d); chk("R9 refresh to zero", d, 8'h00);
    wait_tick(t);
    rd(3'd4, d); chk("R8 escape holds tag", d, 8'h80);
    rd(3'd5, d); chk("R9 refresh holds zero", d, 8'h00);
    wr(3'd4, 8'h05);
    wait_tick(t);
    rd(3'd4, d); chk("R8 escape untagged decrement", d, 8'h04);
    rd(3'd6, d); chk("R10 unmapped read", d, 8'h00);
  endtask

  task automatic t_serial_mask;
    logic [7:0] d;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'hFF);
    @(negedge clk); tx_empty_stb = 1'b1;
    @(negedge clk); tx_empty_stb = 1'b0;
    rd(3'd0, d); chk("R4 tx strobe sets bit7", d[7], 1);
    @(negedge clk);
    chk("R6 masked source keeps irq_n high", irq_n, 1);
    wr(3'd1, 8'h80);
    rd(3'd1, d); chk("R10 mask readback", d, 8'h80);
    @(negedge clk);
    chk("R6 unmasked source lowers irq_n", irq_n, 0);
    @(negedge clk); rx_full_stb = 1'b1;
    @(negedge clk); rx_full_stb = 1'b0;
    rd(3'd0, d); chk("R4 rx strobe sets bit6", d[6], 1);
    wr(3'd0, 8'h80);
    rd(3'd0, d); chk("R5 cleared bit7", d[7], 0);
    chk("R5 zero write keeps bit6", d[6], 1);
    @(negedge clk);
    chk("R6 irq_n high after clear", irq_n, 1);
    // coincident receive event and clear of the same bit
    @(negedge clk);
    rx_full_stb = 1'b1;
    reg_addr = 3'd0; reg_wdata = 8'h40; reg_wr = 1'b1;
    @(negedge clk);
    rx_full_stb = 1'b0; reg_wr = 1'b0;
    rd(3'd0, d); chk("R5 event beats clear", d[6], 1);
    wr(3'd1, 8'h01);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_first_tick();
    t_period();
    t_countdown();
    t_timers();
    t_serial_mask();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule